// File: doc/BRIEF.md
# PCM Frame Synchronization Supervisor

This block supervises the framing of a PCM serial interface. It takes the interface's data clock and frame sync as asynchronous inputs and brings them into the system clock domain through two-flop synchronizers. It then counts data-clock rising edges between frame sync pulses. The block compares each measured frame length with a programmed bit-number value and keeps a single synchronization flag.

Each change of that flag, whether it rises or falls, sets a framing event bit in an interrupt status register. The event bit drives an interrupt pin unless the mask register blocks it. A microcontroller reaches the block through a small register port. Reading the interrupt status register clears the event. Reading the status register changes nothing.

Register map, 8-bit data, 3-bit address:
- 0: interrupt status, read-only, clear-on-read.
- 1: status, read-only.
- 2: interrupt mask, read/write.
- 3: operating mode, read/write.
- 4: bit number, read/write.

Top module: `pcm_sync_supervisor`

## Requirements
- R1: A frame is correct when a frame sync is sampled high at a data-clock rising edge that lies exactly (bit number + 1) rising edges after the previous sync edge. The first sync after enabling only arms the checker. The sync flag is set once two correct frames in a row have followed the arming sync.
- R2: The sync flag is cleared, and the correct-frame run restarts, in either of two cases. The first is a sync pulse at any other count. The second is a missing sync pulse when the count reaches the bit number.
- R3: While bit 0 of the mode register (address 3) is 0, the sync flag is held at 0 and the checker is disarmed.
- R4: Each change of the sync flag, 0 to 1 or 1 to 0, sets bit 3 of the interrupt status register (address 0).
- R5: A read of address 0 clears bit 3 of the interrupt status register. If a sync flag change occurs in the same cycle as that read, the bit stays set.
- R6: The status register (address 1) carries the sync flag at bit 5 and constant ones at bits 0 and 2. A read of address 1 has no side effect on any register.
- R7: The interrupt pin is high when interrupt status bit 3 is set and mask bit 3 (address 2) is 0. A masked event still sets the status bit.
- R8: After reset, the interrupt status reads 0x00, the status reads 0x05, and the mask, mode and bit-number registers read 0x00.
- R9: Read data appears on rdata_o in the cycle after rd_en_i. The mask, mode and bit-number registers read back the value last written. Writes to addresses 0 and 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dclk_i | input | 1 | PCM data clock, asynchronous |
| fsync_i | input | 1 | PCM frame sync, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The embedded assertions check five rules on every cycle:
- A disabled mode keeps the sync flag low.
- Every change of the sync flag leaves the framing event set.
- An event that coincides with an interrupt status read survives the read.
- A status register read never clears the event.
- A set mask bit holds the pin low.

Only the bench scenarios can show the frame-length judgement itself. These scenarios cover short, long and exact frames, too few correct frames, a one-edge frame and loss of sync after lock. The bench also checks reset values, read-back and the pin's response to the mask.

// File: rtl/pcm_sync_supervisor.sv
module pcm_sync_supervisor #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int GOOD_NEEDED = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dclk_i,
  input  logic          fsync_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_ISR  = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_MASK = AW'(2);
  localparam logic [AW-1:0] A_MODE = AW'(3);
  localparam logic [AW-1:0] A_BNUM = AW'(4);
  localparam int GW = $clog2(GOOD_NEEDED + 1);
  localparam int EVT_BIT = 3;
  localparam int SYNC_BIT = 5;

  logic [1:0] dclk_s, fsync_s;
  logic       dclk_d;
  logic [DW-1:0] mask_q, mode_q, bnum_q, cnt_q;
  logic [GW-1:0] good_q, good_nxt;
  logic armed_q, armed_nxt, sync_q, sync_nxt, evt_q;
  logic rise, at_len, enabled, ev, isr_rd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dclk_s  <= '0;
      fsync_s <= '0;
      dclk_d  <= 1'b0;
    end else begin
      dclk_s  <= {dclk_s[0], dclk_i};
      fsync_s <= {fsync_s[0], fsync_i};
      dclk_d  <= dclk_s[1];
    end

  assign rise    = dclk_s[1] & ~dclk_d;
  assign at_len  = (cnt_q == bnum_q);
  assign enabled = mode_q[0];

  always_comb begin
    sync_nxt  = sync_q;
    good_nxt  = good_q;
    armed_nxt = armed_q;
    if (!enabled) begin
      sync_nxt  = 1'b0;
      good_nxt  = '0;
      armed_nxt = 1'b0;
    end else if (rise) begin
      if (fsync_s[1]) begin
        armed_nxt = 1'b1;
        if (armed_q && at_len) begin
          if (good_q < GW'(GOOD_NEEDED)) good_nxt = good_q + 1'b1;
          if (good_q >= GW'(GOOD_NEEDED - 1)) sync_nxt = 1'b1;
        end else if (armed_q) begin
          good_nxt = '0;
          sync_nxt = 1'b0;
        end
      end else if (armed_q && at_len) begin
        good_nxt  = '0;
        sync_nxt  = 1'b0;
        armed_nxt = 1'b0;
      end
    end
  end

  assign ev     = sync_nxt != sync_q;
  assign isr_rd = rd_en_i && addr_i == A_ISR;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q   <= '0;
      good_q  <= '0;
      armed_q <= 1'b0;
      sync_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      good_q  <= good_nxt;
      armed_q <= armed_nxt;
      sync_q  <= sync_nxt;
      if (rise) begin
        if (fsync_s[1])          cnt_q <= '0;
        else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
      end
      if (ev)          evt_q <= 1'b1;
      else if (isr_rd) evt_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
      bnum_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_MASK:  mask_q <= wdata_i;
        A_MODE:  mode_q <= wdata_i;
        A_BNUM:  bnum_q <= wdata_i;
        default: ;
      endcase
    end

  logic [DW-1:0] isr_v, stat_v;
  always_comb begin
    isr_v = '0;
    isr_v[EVT_BIT] = evt_q;
    stat_v = '0;
    stat_v[0] = 1'b1;
    stat_v[2] = 1'b1;
    stat_v[SYNC_BIT] = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata_o <= '0;
    else if (rd_en_i)
      case (addr_i)
        A_ISR:   rdata_o <= isr_v;
        A_STAT:  rdata_o <= stat_v;
        A_MASK:  rdata_o <= mask_q;
        A_MODE:  rdata_o <= mode_q;
        A_BNUM:  rdata_o <= bnum_q;
        default: rdata_o <= '0;
      endcase

  assign irq_o = |(isr_v & ~mask_q);

  assert_off_no_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[0] |=> !sync_q);
  assert_change_sets_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> evt_q);
  assert_event_beats_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && isr_rd) |=> evt_q);
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !ev) |=> !evt_q);
  assert_status_read_harmless_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_STAT && evt_q) |=> evt_q);
  assert_mask_blocks_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[EVT_BIT] |-> !irq_o);
endmodule

// File: tb/pcm_sync_supervisor_tb.sv
module pcm_sync_supervisor_tb;
  logic clk = 0, rst_n = 0, dclk = 0, fsync = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, failures = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  pcm_sync_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .dclk_i(dclk), .fsync_i(fsync),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq));

  // {bit number, frame length in edges, sync pulses, expected sync}
  localparam logic [31:0] VEC [8] = '{
    {8'd7,  8'd8,  8'd3, 8'd1},
    {8'd7,  8'd8,  8'd2, 8'd0},
    {8'd7,  8'd7,  8'd4, 8'd0},
    {8'd7,  8'd9,  8'd4, 8'd0},
    {8'd15, 8'd16, 8'd5, 8'd1},
    {8'd3,  8'd4,  8'd3, 8'd1},
    {8'd0,  8'd1,  8'd4, 8'd1},
    {8'd15, 8'd15, 8'd5, 8'd0}};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic dedge(input logic fs);
    @(negedge clk); dclk = 0; fsync = fs;
    repeat (4) @(negedge clk);
    dclk = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic frames(input int len, input int n);
    for (int p = 0; p < n; p++) begin
      dedge(1);
      if (p != n - 1)
        for (int e = 1; e < len; e++) dedge(0);
    end
    @(negedge clk); dclk = 0; fsync = 0;
    repeat (20) @(negedge clk);
  endtask

  task automatic restart(input logic [7:0] bn);
    wr(3, 0);
    rd(0, v);
    wr(4, bn);
    wr(3, 1);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, v); check("R8 isr reset", v, 8'h00);
    rd(1, v); check("R8 status reset", v, 8'h05);
    rd(2, v); check("R8 mask reset", v, 8'h00);
    rd(3, v); check("R8 mode reset", v, 8'h00);
    rd(4, v); check("R8 bitnum reset", v, 8'h00);
    check("R8 irq reset", {7'd0, irq}, 8'h00);

    wr(4, 8'h5A); rd(4, v); check("R9 bitnum readback", v, 8'h5A);
    wr(2, 8'hF0); rd(2, v); check("R9 mask readback", v, 8'hF0);
    wr(2, 8'h00);
    wr(1, 8'hFF); rd(1, v); check("R9 status write ignored", v, 8'h05);
    wr(0, 8'hFF); rd(0, v); check("R9 isr write ignored", v, 8'h00);

    // R3: frames with mode disabled never sync
    wr(4, 8'd7);
    frames(8, 4);
    rd(1, v); check("R3 disabled status", v, 8'h05);

    for (int i = 0; i < 8; i++) begin
      logic [7:0] bn, ln, np, ex;
      {bn, ln, np, ex} = VEC[i];
      restart(bn);
      frames(int'(ln), int'(np));
      check(ex[0] ? "R1 irq after lock" : "R2 irq quiet", {7'd0, irq}, {7'd0, ex[0]});
      rd(1, v); check(ex[0] ? "R1 sync set" : "R2 sync clear", v, ex[0] ? 8'h25 : 8'h05);
      rd(1, v); check("R6 status reread", v, ex[0] ? 8'h25 : 8'h05);
      rd(0, v); check("R4 event bit", v, ex[0] ? 8'h08 : 8'h00);
      rd(0, v); check("R5 cleared by read", v, 8'h00);
    end

    // R2: lock, then a short frame drops sync and raises the event
    restart(8'd7);
    frames(8, 3);
    rd(0, v);
    dedge(0); dedge(0); dedge(1);
    @(negedge clk); dclk = 0; fsync = 0;
    repeat (20) @(negedge clk);
    rd(1, v); check("R2 short frame loses sync", v, 8'h05);
    rd(0, v); check("R4 falling change sets event", v, 8'h08);

    // R7: masked event sets bit but keeps pin low
    wr(2, 8'h08);
    restart(8'd3);
    frames(4, 3);
    check("R7 masked pin", {7'd0, irq}, 8'h00);
    rd(1, v); check("R7 sync under mask", v, 8'h25);
    wr(2, 8'h00);
    @(negedge clk);
    check("R7 unmasked pin", {7'd0, irq}, 8'h01);
    rd(0, v); check("R7 event bit kept", v, 8'h08);

    // R3: disabling mode after lock drops sync
    wr(3, 0);
    @(negedge clk);
    rd(1, v); check("R3 mode off clears sync", v, 8'h05);
    rd(0, v); check("R4 mode off event", v, 8'h08);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule